// File: doc/BRIEF.md
# Configuration Shadow Capture

This block listens to a configuration broadcast that is sent one word at a time. A producer steps through every (function, index) address in turn and holds each word for a fixed slot of eight core clock cycles. It marks each new word by inverting the level of a single strobe line. The block sees that inversion, waits a set number of cycles so that the word is sampled in the middle of its slot, and then writes the word into a local shadow register file. The file is organised by function number and register index, and each entry carries a valid bit.

User logic reads the shadow file through a simple port. It presents a function and an index, and the stored word appears on the next cycle together with its valid flag. Each completed capture also raises a one-cycle notification that names the entry just written. If the strobe inverts again while a capture is still waiting, the waiting capture is dropped and the timing restarts from the new inversion. A sticky flag records that this happened.

Top module: `cfg_shadow_capture`

## Requirements
- R1: Synchronous active-low reset has these effects. Every valid bit is cleared. `rd_valid_o`, `upd_o` and `overrun_o` read 0. A read of any entry after reset returns valid 0 until a capture writes that entry.
- R2: Both rising and falling changes of `cfg_tgl_i` start a capture. The strobe level seen when reset is released is not treated as a change.
- R3: The capture takes `cfg_addr_i` and `cfg_data_i` at the clock edge that comes `SAMPLE_DLY` cycles after the strobe change (default 4). The stored word is the value present at that edge. Data changes later in the same slot are not stored.
- R4: Address bits [6:4] choose the function (0 to 7) and bits [3:0] choose the index (0 to 15). Each of the 128 pairs has its own 32-bit entry. Writing one entry leaves all other entries unchanged.
- R5: `rd_data_o` and `rd_valid_o` return the entry chosen by `rd_fn_i`/`rd_ix_i` one clock after the choice is presented. An entry that has been written reads valid 1.
- R6: A strobe change that arrives while a capture is waiting drops that capture, so its entry is not written. The delay restarts from the new change, and the new word is captured normally. `overrun_o` goes to 1 and stays at 1 until reset.
- R7: Each completed capture raises `upd_o` for exactly one cycle. During that cycle `upd_fn_o`/`upd_ix_o` give the function and index that were written.
- R8: While the strobe holds its level, changes on `cfg_addr_i` and `cfg_data_i` have no effect. No capture occurs and the stored entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_addr_i | input | 7 | Broadcast address: function [6:4], index [3:0] |
| cfg_data_i | input | 32 | Broadcast register word |
| cfg_tgl_i | input | 1 | Strobe that changes level on each new word |
| rd_fn_i | input | 3 | Read function number |
| rd_ix_i | input | 4 | Read register index |
| rd_data_o | output | 32 | Stored word, one cycle after the request |
| rd_valid_o | output | 1 | Entry has been written since reset |
| upd_o | output | 1 | One-cycle pulse for each completed capture |
| upd_fn_o | output | 3 | Function of the entry just written |
| upd_ix_o | output | 4 | Index of the entry just written |
| overrun_o | output | 1 | Sticky: a waiting capture was dropped |

## Verification
The hardest condition to reach from the ports is a dropped capture. A correct broadcaster never changes the strobe inside the sampling delay, so the only way to exercise R6 is to break the slot spacing on purpose. The bench's model broadcaster takes a slot length as an argument. One slot is given two cycles in place of eight, so the next strobe change lands while the first capture is still waiting. The bench then checks that the dropped entry still holds its earlier value, that the following entry is written, and that exactly one update pulse appeared for the pair. To test mid-slot sampling, every full slot alters the data word right after the sampling edge, so a capture at the wrong cycle would store the wrong word.

// File: rtl/cfgcap_pkg.sv
// Package: shared default widths for the configuration shadow capture block.
// Assumes: the broadcast address is the function field above the index field.
package cfgcap_pkg;
    localparam int unsigned FN_W_DEF   = 3;   // function number width
    localparam int unsigned IX_W_DEF   = 4;   // register index width
    localparam int unsigned WORD_W_DEF = 32;  // register word width
    localparam int unsigned DLY_DEF    = 4;   // cycles from strobe change to sample
endpackage

// File: rtl/cfgcap_toggle_det.sv
// Module: detects any level change of a toggle-style strobe.
// Assumes: the strobe is synchronous to clk. The level seen on the first
// clock after reset is taken as the reference and is not reported as a change.
module cfgcap_toggle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    output logic chg_o
);
    logic stb_q;
    logic seeded_q;

    // Purpose: remember the previous strobe level and note that it is known.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q    <= 1'b0;
            seeded_q <= 1'b0;
        end else begin
            stb_q    <= stb_i;
            seeded_q <= 1'b1;
        end
    end

    // Purpose: flag a change in either direction once a reference level exists.
    always_comb begin
        chg_o = seeded_q & (stb_i ^ stb_q);
    end
endmodule

// File: rtl/cfgcap_sample_timer.sv
// Module: delays each strobe change by DLY cycles and then issues one sample
// strobe. A change that arrives while a sample is waiting restarts the delay
// and sets a sticky overrun flag.
// Assumes: 1 <= DLY <= 7, so the sample falls inside an eight-cycle slot.
module cfgcap_sample_timer #(
    parameter int unsigned DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    output logic fire_o,
    output logic pending_o,
    output logic overrun_o
);
    localparam int unsigned CNT_W = (DLY > 1) ? $clog2(DLY) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             ovr_q;

    // Purpose: load, count down and clear the pending sample; record overruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            ovr_q  <= 1'b0;
        end else if (chg_i) begin
            pend_q <= 1'b1;
            cnt_q  <= CNT_W'(DLY - 1);
            if (pend_q) begin
                ovr_q <= 1'b1;
            end
        end else if (pend_q) begin
            if (cnt_q == '0) begin
                pend_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Purpose: sample when the count expires and no new change is present.
    always_comb begin
        fire_o    = pend_q & (cnt_q == '0) & ~chg_i;
        pending_o = pend_q;
        overrun_o = ovr_q;
    end
endmodule

// File: rtl/cfgcap_shadow_bank.sv
// Module: shadow register file with one word and one valid bit per
// (function, index). One write port and one registered read port.
// Assumes: a read of the entry being written in the same cycle returns the
// old contents. Word storage is not reset, and only the valid bits clear.
module cfgcap_shadow_bank #(
    parameter int unsigned FN_W   = 3,
    parameter int unsigned IX_W   = 4,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [FN_W-1:0]   wr_fn_i,
    input  logic [IX_W-1:0]   wr_ix_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  logic [FN_W-1:0]   rd_fn_i,
    input  logic [IX_W-1:0]   rd_ix_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              rd_valid_o
);
    localparam int unsigned AW    = FN_W + IX_W;
    localparam int unsigned DEPTH = 1 << AW;

    logic [WORD_W-1:0] words_q [DEPTH];
    logic [DEPTH-1:0]  valid_q;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;

    // Purpose: form flat addresses from the function and index fields.
    always_comb begin
        waddr = {wr_fn_i, wr_ix_i};
        raddr = {rd_fn_i, rd_ix_i};
    end

    // Purpose: store captured words (no reset needed on data).
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            words_q[waddr] <= wr_word_i;
        end
    end

    // Purpose: track which entries hold a captured word since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[waddr] <= 1'b1;
        end
    end

    // Purpose: registered read of the requested entry and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_word_o  <= words_q[raddr];
            rd_valid_o <= valid_q[raddr];
        end
    end
endmodule

// File: rtl/cfg_shadow_capture.sv
// Module: top of the configuration shadow capture block. It detects strobe
// changes, samples the broadcast word SAMPLE_DLY cycles later, writes it into
// the shadow bank and announces the write with a one-cycle pulse.
// Assumes: address, data and strobe are synchronous to clk. Each slot lasts
// longer than SAMPLE_DLY cycles, and a shorter slot is reported as overrun.
module cfg_shadow_capture #(
    parameter int unsigned FN_W       = cfgcap_pkg::FN_W_DEF,
    parameter int unsigned IX_W       = cfgcap_pkg::IX_W_DEF,
    parameter int unsigned DATA_W     = cfgcap_pkg::WORD_W_DEF,
    parameter int unsigned SAMPLE_DLY = cfgcap_pkg::DLY_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FN_W+IX_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0]    cfg_data_i,
    input  logic                 cfg_tgl_i,
    input  logic [FN_W-1:0]      rd_fn_i,
    input  logic [IX_W-1:0]      rd_ix_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 rd_valid_o,
    output logic                 upd_o,
    output logic [FN_W-1:0]      upd_fn_o,
    output logic [IX_W-1:0]      upd_ix_o,
    output logic                 overrun_o
);
    localparam int unsigned AW = FN_W + IX_W;

    logic            tgl_edge;
    logic            fire;
    logic            pending_w;
    logic [FN_W-1:0] cap_fn;
    logic [IX_W-1:0] cap_ix;

    // Purpose: split the broadcast address into its function and index fields.
    always_comb begin
        cap_fn = cfg_addr_i[AW-1:IX_W];
        cap_ix = cfg_addr_i[IX_W-1:0];
    end

    cfgcap_toggle_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (cfg_tgl_i),
        .chg_o (tgl_edge)
    );

    cfgcap_sample_timer #(
        .DLY (SAMPLE_DLY)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_i     (tgl_edge),
        .fire_o    (fire),
        .pending_o (pending_w),
        .overrun_o (overrun_o)
    );

    cfgcap_shadow_bank #(
        .FN_W   (FN_W),
        .IX_W   (IX_W),
        .WORD_W (DATA_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (fire),
        .wr_fn_i    (cap_fn),
        .wr_ix_i    (cap_ix),
        .wr_word_i  (cfg_data_i),
        .rd_fn_i    (rd_fn_i),
        .rd_ix_i    (rd_ix_i),
        .rd_word_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    // Purpose: announce each completed capture with its entry address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_o    <= 1'b0;
            upd_fn_o <= '0;
            upd_ix_o <= '0;
        end else begin
            upd_o <= fire;
            if (fire) begin
                upd_fn_o <= cap_fn;
                upd_ix_o <= cap_ix;
            end
        end
    end
endmodule

// File: rtl/cfgcap_checker.sv
// Module: temporal checks for cfg_shadow_capture, attached with bind.
// Assumes: it is connected to the top's internal change and pending signals.
module cfgcap_checker (
    input logic clk,
    input logic rst_n,
    input logic tgl_edge,
    input logic pending,
    input logic upd,
    input logic ovr
);
    // R7: the update notification never lasts longer than one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

    // R3: a write is only announced after a sample was waiting
    a_r3_upd_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(pending));

    // R6: a change that arrives while a sample is waiting raises the overrun flag
    a_r6_flag_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tgl_edge) |=> ovr);

    // R6: once raised, the overrun flag stays set
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);
endmodule

bind cfg_shadow_capture cfgcap_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tgl_edge (tgl_edge),
    .pending  (pending_w),
    .upd      (upd_o),
    .ovr      (overrun_o)
);

// File: tb/sim_cfg_shadow_capture.sv
module sim_cfg_shadow_capture;
    localparam int DLY  = 4;
    localparam int SLOT = 8;
    localparam int N    = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        cfg_tgl = 1'b1;
    logic [2:0]  rd_fn = '0;
    logic [3:0]  rd_ix = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        upd;
    logic [2:0]  upd_fn;
    logic [3:0]  upd_ix;
    logic        overrun;

    int checks = 0, fails = 0;
    int mon_checks = 0, mon_fails = 0;
    int upd_seen = 0;
    bit wd_fail = 0, done = 0, upd_prev = 0;
    logic [6:0] cur_addr = '0;

    always #4 clk = ~clk;

    cfg_shadow_capture #(.SAMPLE_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
        .cfg_tgl_i(cfg_tgl), .rd_fn_i(rd_fn), .rd_ix_i(rd_ix),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .upd_o(upd),
        .upd_fn_o(upd_fn), .upd_ix_o(upd_ix), .overrun_o(overrun)
    );

    function automatic logic [31:0] word_of(int pass, int a);
        return (32'(a) * 32'h9E37_79B1) ^ (32'(pass) << 28) ^ 32'h0000_5A5A;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R7 monitor: each pulse names the current slot and lasts one cycle
    always @(negedge clk) begin
        if (rst_n && upd) begin
            upd_seen++;
            mon_checks++;
            if ({upd_fn, upd_ix} != cur_addr) begin
                mon_fails++;
                $display("FAIL R7 upd address actual=%h expected=%h", {upd_fn, upd_ix}, cur_addr);
            end
            if (upd_prev) begin
                mon_fails++;
                $display("FAIL R7 pulse width actual=%0d expected=%0d", 2, 1);
            end
        end
        upd_prev = rst_n && upd;
    end

    // Model broadcaster: one word per slot; a full slot alters data after the sample edge
    task automatic slot(logic [6:0] a, logic [31:0] d, int len);
        cfg_addr = a;
        cfg_data = d;
        cfg_tgl  = ~cfg_tgl;
        cur_addr = a;
        if (len > DLY) begin
            repeat (DLY + 1) @(negedge clk);
            cfg_data = ~d;
            repeat (len - DLY - 1) @(negedge clk);
        end else begin
            repeat (len) @(negedge clk);
        end
    endtask

    task automatic rd(int a, output logic [31:0] d, output logic v);
        rd_fn = a[6:4];
        rd_ix = a[3:0];
        @(negedge clk);
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks + int'(wd_fail),
                 fails + mon_fails + int'(wd_fail));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            wd_fail = 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(upd == 0, "R1", "upd after reset", 32'(upd), 0);
        chk(overrun == 0, "R1", "overrun after reset", 32'(overrun), 0);
        chk(rd_valid == 0, "R1", "rd_valid after reset", 32'(rd_valid), 0);
        repeat (10) @(negedge clk);
        chk(upd_seen == 0, "R2", "no capture from reset level", 32'(upd_seen), 0);
        for (int a = 0; a < N; a++) begin
            rd(a, d, v);
            chk(v == 0, "R1", "entry invalid after reset", 32'(v), 0);
        end

        // Pass 0: full sweep, strobe alternates falling and rising
        for (int a = 0; a < N; a++) slot(7'(a), word_of(0, a), SLOT);
        chk(upd_seen == N, "R2", "captures in both directions", 32'(upd_seen), 32'(N));
        chk(overrun == 0, "R6", "no overrun on regular slots", 32'(overrun), 0);
        for (int a = 0; a < N; a++) begin
            rd(a, d, v);
            chk(v == 1, "R5", "entry valid", 32'(v), 1);
            chk(d == word_of(0, a), "R3", "mid-slot word stored", d, word_of(0, a));
        end

        // Strobe held: address and data wander with no effect
        n = upd_seen;
        for (int i = 0; i < 40; i++) begin
            cfg_addr = 7'h12;
            cfg_data = 32'h1111_0000 + 32'(i);
            @(negedge clk);
        end
        chk(upd_seen == n, "R8", "no capture without strobe change", 32'(upd_seen), 32'(n));
        rd(7'h12, d, v);
        chk(d == word_of(0, 7'h12), "R8", "entry unchanged while quiet", d, word_of(0, 7'h12));

        // Pass 1: rewrite only function 5
        for (int ix = 0; ix < 16; ix++) slot({3'd5, 4'(ix)}, word_of(1, 80 + ix), SLOT);
        for (int a = 0; a < N; a++) begin
            rd(a, d, v);
            chk(d == word_of((a >> 4) == 5 ? 1 : 0, a), "R4", "per-function entry",
                d, word_of((a >> 4) == 5 ? 1 : 0, a));
        end

        // Short slot: second change lands while the first sample waits
        n = upd_seen;
        slot(7'h23, 32'hDEAD_BEEF, 2);
        slot(7'h24, word_of(2, 7'h24), SLOT);
        chk(overrun == 1, "R6", "overrun raised", 32'(overrun), 1);
        chk(upd_seen == n + 1, "R6", "one capture for the pair", 32'(upd_seen), 32'(n + 1));
        rd(7'h23, d, v);
        chk(d == word_of(0, 7'h23), "R6", "dropped entry unchanged", d, word_of(0, 7'h23));
        rd(7'h24, d, v);
        chk(d == word_of(2, 7'h24), "R6", "restarted capture stored", d, word_of(2, 7'h24));
        slot(7'h30, word_of(2, 7'h30), SLOT);
        chk(overrun == 1, "R6", "overrun sticky", 32'(overrun), 1);
        rd(7'h30, d, v);
        chk(d == word_of(2, 7'h30) && v, "R5", "later capture still works", d, word_of(2, 7'h30));

        done = 1;
        report();
        $finish;
    end
endmodule